// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block steers a small processor system through four power modes: active, idle, standby and shutdown. Software asks for a deeper mode with a request code. The controller then gates the CPU clock, switches memory, radio, peripheral and always-on domain enables, and holds the I/O pins at their last values. It also runs the brown-out detector either all the time or only in short recharge windows. Each mode has its own set of wake sources. A wake-up does not reach the CPU at once: a down-counter, sized from the reference clock frequency, runs first, and the CPU is told it may run only when that counter reaches zero.

A wake from shutdown restarts the system. The same applies when the external reset pin is released. A power-on reset, a reset-pin event and a shutdown pin wake each set their own bit in a cause register, and software clears those bits by writing ones. If the brown-out detector trips during a standby recharge window, the system does not resume after wake. It stays locked until the reset pin is pulled or power is cycled.

All control and status pins are plain levels or single-cycle pulses. The block has no streaming data path, so no valid/ready handshake applies. A mode request is taken in the cycle `mode_req_valid` is high and cannot be stalled.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `por_n` is released, `mode_now` is 0 (active), `rst_cause` is 3'b001 (bit 0 = power-on), `cpu_ready` is 1 and `req_err` is 0.
- R2: In active, a request with `mode_req_valid` high and code 1, 2 or 3 moves `mode_now` to 1 (idle), 2 (standby) or 3 (shutdown) at the next clock edge. Code 0 changes nothing.
- R3: In idle, a pulse on `irq`, `rtc_evt`, `pin_edge_evt` or `sensor_evt` makes `cpu_ready` rise exactly 14*CLK_MHZ edges after the edge that samples the pulse. `mode_now` reads 4 (waking) in between.
- R4: In standby, `irq` and `wake_pin_chg` are ignored and the mode stays 2. `rtc_evt`, `pin_edge_evt` or `sensor_evt` raises `cpu_ready` after 151*CLK_MHZ edges.
- R5: In shutdown, only `wake_pin_chg` (or the reset pin) exits. The exit sets `rst_cause` bit 2 and holds `sys_rst` high through the 1015*CLK_MHZ-edge wake count. `bod_en` is 0 in shutdown.
- R6: While `rst_pin_n` is low, `mode_now` is 6 and the CPU clock, all power enables and `io_hold` are 0, and `sys_rst` is 1. On entry, `rst_cause` bit 1 is set. After release, a 1015*CLK_MHZ-edge wake with `sys_rst` high leads to active.
- R7: A one on a bit of `cause_clr` clears that `rst_cause` bit at the next edge. A reset event in the same cycle still sets its bit.
- R8: `io_hold` is 1 in standby and shutdown, and while waking from them. It is 0 in active and idle.
- R9: The CPU clock runs only in active. Idle keeps the peripheral clock, flash and SRAM on. Standby keeps only SRAM and the always-on domain on. Shutdown turns off everything, including the always-on domain.
- R10: In standby, `bod_en` is high only in the last BOD_WIN cycles of every BOD_PERIOD-cycle period, counted from entry. A `bod_trip` sampled outside that window has no effect.
- R11: A `bod_trip` sampled while `bod_en` is high in standby makes the next standby wake go to mode 5 (locked). In that mode `lock_out` is 1 and `cpu_ready` is 0 until the reset pin or power-on reset.
- R12: A request made outside active is ignored and sets `req_err`. `req_err` stays set until `rst_pin_n` goes low or power-on reset.
- R13: `cpu_ready` is high only in active. It is low, and the CPU clock is gated, for the whole wake count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_pin_n | input | 1 | External reset pin, synchronous, active low |
| mode_req_valid | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode: 0 active, 1 idle, 2 standby, 3 shutdown |
| irq | input | 1 | Ordinary peripheral interrupt |
| rtc_evt | input | 1 | Real-time clock event |
| pin_edge_evt | input | 1 | Pin edge event from the always-on domain |
| sensor_evt | input | 1 | Autonomous sensor engine event |
| wake_pin_chg | input | 1 | State change on a pin armed for shutdown wake |
| bod_trip | input | 1 | Brown-out comparator output |
| cause_clr | input | 3 | Write-one-to-clear pulse for the cause bits |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_pwr_en | output | 1 | Flash power enable |
| sram_pwr_en | output | 1 | SRAM power enable |
| radio_pwr_en | output | 1 | Radio power enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| aon_pwr_en | output | 1 | Always-on domain power enable |
| io_hold | output | 1 | Hold the I/O outputs at their last values |
| bod_en | output | 1 | Brown-out detector enable |
| sys_rst | output | 1 | System reset to the CPU and its peripherals |
| cpu_ready | output | 1 | CPU may run (active mode) |
| lock_out | output | 1 | Locked after a brown-out trip |
| req_err | output | 1 | Sticky flag for an ignored request |
| mode_now | output | 3 | 0 active, 1 idle, 2 standby, 3 shutdown, 4 waking, 5 locked, 6 reset held |
| rst_cause | output | 3 | Bit 0 power-on, bit 1 reset pin, bit 2 shutdown pin wake |

## Verification
A wrong mode register shows on `mode_now` and on the power enables at the next clock edge. The bench therefore checks the mode code together with the enable pattern right after every request and every wake pulse. A wake counter that is loaded with the wrong value, or that stops early, is caught by sampling `cpu_ready` exactly one edge before and exactly at the expected latency. An off-by-one therefore fails on the first wake from each mode. A lost lock flag or a misplaced recharge window stays hidden until the next standby wake, so the bench wakes the system after both an in-window trip and an out-of-window trip.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE   = 3'd0,
    PM_IDLE     = 3'd1,
    PM_STANDBY  = 3'd2,
    PM_SHUTDOWN = 3'd3,
    PM_WAKE     = 3'd4,
    PM_LOCK     = 3'd5,
    PM_RSTHOLD  = 3'd6
  } pm_state_e;

  typedef enum logic [1:0] {
    REQ_ACTIVE   = 2'd0,
    REQ_IDLE     = 2'd1,
    REQ_STANDBY  = 2'd2,
    REQ_SHUTDOWN = 2'd3
  } pm_req_e;

  localparam int CAUSE_W    = 3;
  localparam int CAUSE_POR  = 0;
  localparam int CAUSE_PIN  = 1;
  localparam int CAUSE_SHDN = 2;

  typedef struct packed {
    logic cpu_clk;
    logic flash;
    logic sram;
    logic radio;
    logic periph;
    logic aon;
    logic io_hold;
    logic bod_full;
    logic sys_rst;
  } pm_ctrl_t;

endpackage

// File: rtl/pwr_wake_timer.sv
`timescale 1ns/1ps
// Wake latency down-counter: loaded with N-1, done when it reaches zero.
module pwr_wake_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pwr_bod_duty.sv
`timescale 1ns/1ps
// Standby recharge window generator for the brown-out detector.
module pwr_bod_duty #(
  parameter int PERIOD = 16,
  parameter int WIN    = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic in_stby,
  input  logic bod_trip,
  output logic win_en,
  output logic trip_hit
);

  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST  = PW'(PERIOD - 1);
  localparam logic [PW-1:0] OPENS = PW'(PERIOD - WIN);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      phase_q <= '0;
    else if (!in_stby)
      phase_q <= '0;
    else if (phase_q == LAST)
      phase_q <= '0;
    else
      phase_q <= phase_q + 1'b1;
  end

  assign win_en   = in_stby && (phase_q >= OPENS);
  assign trip_hit = win_en && bod_trip;

endmodule

// File: rtl/pwr_cause_reg.sv
`timescale 1ns/1ps
// Reset cause bits: set wins over a write-one-to-clear in the same cycle.
module pwr_cause_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] cause
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    localparam logic POR_VAL = (b == 0);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
        cause[b] <= POR_VAL;
      else
        cause[b] <= (cause[b] & ~clr_v[b]) | set_v[b];
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int CLK_MHZ    = 1,
  parameter int IDLE_US    = 14,
  parameter int STBY_US    = 151,
  parameter int SHDN_US    = 1015,
  parameter int BOD_PERIOD = 16,
  parameter int BOD_WIN    = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_pin_n,
  input  logic       mode_req_valid,
  input  logic [1:0] mode_req,
  input  logic       irq,
  input  logic       rtc_evt,
  input  logic       pin_edge_evt,
  input  logic       sensor_evt,
  input  logic       wake_pin_chg,
  input  logic       bod_trip,
  input  logic [2:0] cause_clr,
  output logic       cpu_clk_en,
  output logic       flash_pwr_en,
  output logic       sram_pwr_en,
  output logic       radio_pwr_en,
  output logic       periph_clk_en,
  output logic       aon_pwr_en,
  output logic       io_hold,
  output logic       bod_en,
  output logic       sys_rst,
  output logic       cpu_ready,
  output logic       lock_out,
  output logic       req_err,
  output logic [2:0] mode_now,
  output logic [2:0] rst_cause
);

  localparam int IDLE_CYC = IDLE_US * CLK_MHZ;
  localparam int STBY_CYC = STBY_US * CLK_MHZ;
  localparam int SHDN_CYC = SHDN_US * CLK_MHZ;
  localparam int MAX_CYC  = (SHDN_CYC > STBY_CYC) ?
                            ((SHDN_CYC > IDLE_CYC) ? SHDN_CYC : IDLE_CYC) :
                            ((STBY_CYC > IDLE_CYC) ? STBY_CYC : IDLE_CYC);
  localparam int TW       = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] IDLE_LD = TW'(IDLE_CYC - 1);
  localparam logic [TW-1:0] STBY_LD = TW'(STBY_CYC - 1);
  localparam logic [TW-1:0] SHDN_LD = TW'(SHDN_CYC - 1);

  pm_state_e state_q, state_d;
  logic      deep_q, deep_d;
  logic      wrst_q, wrst_d;
  logic      lock_q, lock_d;
  logic      err_q, err_d;
  logic      t_load, t_done;
  logic [TW-1:0] t_val;
  logic [CAUSE_W-1:0] cause_set;
  logic      win_en, trip_hit;
  logic      any_int, stby_wake;
  pm_ctrl_t  ctl;

  pwr_wake_timer #(.CW(TW)) u_timer (
    .clk      (clk),
    .por_n    (por_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  pwr_bod_duty #(.PERIOD(BOD_PERIOD), .WIN(BOD_WIN)) u_bod (
    .clk      (clk),
    .por_n    (por_n),
    .in_stby  (state_q == PM_STANDBY),
    .bod_trip (bod_trip),
    .win_en   (win_en),
    .trip_hit (trip_hit)
  );

  pwr_cause_reg #(.N(CAUSE_W)) u_cause (
    .clk   (clk),
    .por_n (por_n),
    .set_v (cause_set),
    .clr_v (cause_clr),
    .cause (rst_cause)
  );

  assign any_int   = irq | rtc_evt | pin_edge_evt | sensor_evt;
  assign stby_wake = rtc_evt | pin_edge_evt | sensor_evt;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    deep_d    = deep_q;
    wrst_d    = wrst_q;
    lock_d    = lock_q;
    err_d     = err_q;
    t_load    = 1'b0;
    t_val     = '0;
    cause_set = '0;
    if (!rst_pin_n) begin
      state_d = PM_RSTHOLD;
      lock_d  = 1'b0;
      err_d   = 1'b0;
      deep_d  = 1'b0;
      wrst_d  = 1'b1;
      if (state_q != PM_RSTHOLD)
        cause_set[CAUSE_PIN] = 1'b1;
    end else begin
      if (mode_req_valid && state_q != PM_ACTIVE)
        err_d = 1'b1;
      unique case (state_q)
        PM_ACTIVE: begin
          if (mode_req_valid) begin
            unique case (pm_req_e'(mode_req))
              REQ_IDLE:     state_d = PM_IDLE;
              REQ_STANDBY:  state_d = PM_STANDBY;
              REQ_SHUTDOWN: state_d = PM_SHUTDOWN;
              default:      state_d = PM_ACTIVE;
            endcase
          end
        end
        PM_IDLE: begin
          if (any_int) begin
            state_d = PM_WAKE;
            t_load  = 1'b1;
            t_val   = IDLE_LD;
            deep_d  = 1'b0;
            wrst_d  = 1'b0;
          end
        end
        PM_STANDBY: begin
          if (trip_hit)
            lock_d = 1'b1;
          if (stby_wake) begin
            if (lock_d) begin
              state_d = PM_LOCK;
            end else begin
              state_d = PM_WAKE;
              t_load  = 1'b1;
              t_val   = STBY_LD;
              deep_d  = 1'b1;
              wrst_d  = 1'b0;
            end
          end
        end
        PM_SHUTDOWN: begin
          if (wake_pin_chg) begin
            state_d = PM_WAKE;
            t_load  = 1'b1;
            t_val   = SHDN_LD;
            deep_d  = 1'b1;
            wrst_d  = 1'b1;
            cause_set[CAUSE_SHDN] = 1'b1;
          end
        end
        PM_WAKE: begin
          if (t_done) begin
            state_d = PM_ACTIVE;
            deep_d  = 1'b0;
            wrst_d  = 1'b0;
          end
        end
        PM_LOCK: state_d = PM_LOCK;
        PM_RSTHOLD: begin
          state_d = PM_WAKE;
          t_load  = 1'b1;
          t_val   = SHDN_LD;
          deep_d  = 1'b0;
          wrst_d  = 1'b1;
        end
        default: state_d = PM_RSTHOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= PM_ACTIVE;
      deep_q  <= 1'b0;
      wrst_q  <= 1'b0;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      deep_q  <= deep_d;
      wrst_q  <= wrst_d;
      lock_q  <= lock_d;
      err_q   <= err_d;
    end
  end

  // per-mode domain control
  always_comb begin
    ctl = '0;
    unique case (state_q)
      PM_ACTIVE:   ctl = '{cpu_clk:1'b1, flash:1'b1, sram:1'b1, radio:1'b1, periph:1'b1,
                           aon:1'b1, io_hold:1'b0, bod_full:1'b1, sys_rst:1'b0};
      PM_IDLE:     ctl = '{cpu_clk:1'b0, flash:1'b1, sram:1'b1, radio:1'b1, periph:1'b1,
                           aon:1'b1, io_hold:1'b0, bod_full:1'b1, sys_rst:1'b0};
      PM_STANDBY:  ctl = '{cpu_clk:1'b0, flash:1'b0, sram:1'b1, radio:1'b0, periph:1'b0,
                           aon:1'b1, io_hold:1'b1, bod_full:1'b0, sys_rst:1'b0};
      PM_SHUTDOWN: ctl = '{cpu_clk:1'b0, flash:1'b0, sram:1'b0, radio:1'b0, periph:1'b0,
                           aon:1'b0, io_hold:1'b1, bod_full:1'b0, sys_rst:1'b1};
      PM_WAKE:     ctl = '{cpu_clk:1'b0, flash:1'b1, sram:1'b1, radio:1'b0, periph:1'b0,
                           aon:1'b1, io_hold:deep_q, bod_full:1'b1, sys_rst:wrst_q};
      PM_LOCK:     ctl = '{cpu_clk:1'b0, flash:1'b0, sram:1'b0, radio:1'b0, periph:1'b0,
                           aon:1'b1, io_hold:1'b1, bod_full:1'b0, sys_rst:1'b0};
      PM_RSTHOLD:  ctl = '{cpu_clk:1'b0, flash:1'b0, sram:1'b0, radio:1'b0, periph:1'b0,
                           aon:1'b0, io_hold:1'b0, bod_full:1'b0, sys_rst:1'b1};
      default:     ctl = '0;
    endcase
  end

  assign cpu_clk_en    = ctl.cpu_clk;
  assign flash_pwr_en  = ctl.flash;
  assign sram_pwr_en   = ctl.sram;
  assign radio_pwr_en  = ctl.radio;
  assign periph_clk_en = ctl.periph;
  assign aon_pwr_en    = ctl.aon;
  assign io_hold       = ctl.io_hold;
  assign bod_en        = ctl.bod_full | win_en;
  assign sys_rst       = ctl.sys_rst;
  assign cpu_ready     = (state_q == PM_ACTIVE);
  assign lock_out      = (state_q == PM_LOCK);
  assign req_err       = err_q;
  assign mode_now      = state_q;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
`timescale 1ns/1ps
module pwr_mode_seq_chk
  import pwr_mode_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       rst_pin_n,
  input logic       irq,
  input logic       rtc_evt,
  input logic       pin_edge_evt,
  input logic       sensor_evt,
  input logic       wake_pin_chg,
  input logic [2:0] cause_clr,
  input logic       cpu_clk_en,
  input logic       io_hold,
  input logic       bod_en,
  input logic       sys_rst,
  input logic       cpu_ready,
  input logic       lock_out,
  input logic       req_err,
  input logic [2:0] mode_now,
  input logic [2:0] rst_cause
);

  p_stby_irq_ignored_r4: assert property (@(posedge clk) disable iff (!por_n)
    (mode_now == PM_STANDBY && rst_pin_n && !rtc_evt && !pin_edge_evt && !sensor_evt)
      |=> (mode_now == PM_STANDBY || mode_now == PM_LOCK) && (irq || !irq));

  p_shdn_stays_r5: assert property (@(posedge clk) disable iff (!por_n)
    (mode_now == PM_SHUTDOWN && rst_pin_n && !wake_pin_chg) |=> mode_now == PM_SHUTDOWN);

  p_shdn_wake_cause_r5: assert property (@(posedge clk) disable iff (!por_n)
    (mode_now == PM_SHUTDOWN && rst_pin_n && wake_pin_chg) |=> rst_cause[2] && sys_rst);

  p_shdn_bod_off_r5: assert property (@(posedge clk) disable iff (!por_n)
    (mode_now == PM_SHUTDOWN) |-> !bod_en);

  p_pin_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    !rst_pin_n |=> mode_now == PM_RSTHOLD && sys_rst && rst_cause[1]);

  p_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
    (rst_pin_n && cause_clr[1]) |=> !rst_cause[1]);

  p_hold_deep_r8: assert property (@(posedge clk) disable iff (!por_n)
    (mode_now == PM_STANDBY || mode_now == PM_SHUTDOWN) |-> io_hold);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
    (lock_out && rst_pin_n) |=> lock_out && !cpu_ready);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!por_n)
    (req_err && rst_pin_n) |=> req_err);

  p_wake_gated_r13: assert property (@(posedge clk) disable iff (!por_n)
    (mode_now == PM_WAKE) |-> !cpu_ready && !cpu_clk_en);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .rst_pin_n    (rst_pin_n),
  .irq          (irq),
  .rtc_evt      (rtc_evt),
  .pin_edge_evt (pin_edge_evt),
  .sensor_evt   (sensor_evt),
  .wake_pin_chg (wake_pin_chg),
  .cause_clr    (cause_clr),
  .cpu_clk_en   (cpu_clk_en),
  .io_hold      (io_hold),
  .bod_en       (bod_en),
  .sys_rst      (sys_rst),
  .cpu_ready    (cpu_ready),
  .lock_out     (lock_out),
  .req_err      (req_err),
  .mode_now     (mode_now),
  .rst_cause    (rst_cause)
);

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_pin_n = 1'b1;
  logic       mode_req_valid = 1'b0;
  logic [1:0] mode_req = 2'd0;
  logic       irq = 1'b0, rtc_evt = 1'b0, pin_edge_evt = 1'b0, sensor_evt = 1'b0;
  logic       wake_pin_chg = 1'b0, bod_trip = 1'b0;
  logic [2:0] cause_clr = 3'd0;
  logic cpu_clk_en, flash_pwr_en, sram_pwr_en, radio_pwr_en, periph_clk_en, aon_pwr_en;
  logic io_hold, bod_en, sys_rst, cpu_ready, lock_out, req_err;
  logic [2:0] mode_now, rst_cause;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwr_mode_seq u_pwr_mode_seq (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .irq(irq), .rtc_evt(rtc_evt), .pin_edge_evt(pin_edge_evt), .sensor_evt(sensor_evt),
    .wake_pin_chg(wake_pin_chg), .bod_trip(bod_trip), .cause_clr(cause_clr),
    .cpu_clk_en(cpu_clk_en), .flash_pwr_en(flash_pwr_en), .sram_pwr_en(sram_pwr_en),
    .radio_pwr_en(radio_pwr_en), .periph_clk_en(periph_clk_en), .aon_pwr_en(aon_pwr_en),
    .io_hold(io_hold), .bod_en(bod_en), .sys_rst(sys_rst), .cpu_ready(cpu_ready),
    .lock_out(lock_out), .req_err(req_err), .mode_now(mode_now), .rst_cause(rst_cause)
  );

  // wake table: requested mode, wake source (0 irq,1 rtc,2 pin edge,3 sensor,4 wake pin)
  localparam int NV = 8;
  localparam int V_REQ [NV] = '{1, 1, 1, 1, 2, 2, 2, 3};
  localparam int V_SRC [NV] = '{0, 1, 2, 3, 1, 2, 3, 4};

  function automatic int lat_of(input int req);
    if (req == 1) return 14;
    if (req == 2) return 151;
    return 1015;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input int code);
    mode_req_valid = 1'b1;
    mode_req = 2'(code);
    tick();
    mode_req_valid = 1'b0;
    mode_req = 2'd0;
  endtask

  task automatic pulse(input int src);
    case (src)
      0: irq = 1'b1;
      1: rtc_evt = 1'b1;
      2: pin_edge_evt = 1'b1;
      3: sensor_evt = 1'b1;
      default: wake_pin_chg = 1'b1;
    endcase
    tick();
    irq = 1'b0; rtc_evt = 1'b0; pin_edge_evt = 1'b0; sensor_evt = 1'b0; wake_pin_chg = 1'b0;
  endtask

  task automatic wait_ready(input string req, input int lat);
    repeat (lat - 1) tick();
    check({req, " ready low one edge early"}, cpu_ready, 0);
    tick();
    check({req, " ready at latency"}, cpu_ready, 1);
    check({req, " active after wake"}, mode_now, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 mode", mode_now, 0);
    check("R1 cause", rst_cause, 3'b001);
    check("R1 ready", cpu_ready, 1);
    check("R1 err", req_err, 0);
    check("R9 active cpu clk", cpu_clk_en, 1);
    check("R8 active no hold", io_hold, 0);
    request(0);
    check("R2 code 0 no-op", mode_now, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      request(V_REQ[i]);
      check("R2 mode after request", mode_now, V_REQ[i]);
      if (V_REQ[i] == 1) begin
        check("R9 idle cpu gated", cpu_clk_en, 0);
        check("R9 idle periph on", {periph_clk_en, flash_pwr_en, sram_pwr_en}, 3'b111);
        check("R8 idle no hold", io_hold, 0);
      end else if (V_REQ[i] == 2) begin
        check("R9 standby domains", {flash_pwr_en, sram_pwr_en, periph_clk_en, aon_pwr_en}, 4'b0101);
        check("R8 standby hold", io_hold, 1);
      end else begin
        check("R9 shutdown all off", {sram_pwr_en, aon_pwr_en, cpu_clk_en}, 3'b000);
        check("R8 shutdown hold", io_hold, 1);
      end
      pulse(V_SRC[i]);
      check("R13 waking mode", mode_now, 4);
      if (V_REQ[i] == 3) begin
        check("R5 sys_rst during wake", sys_rst, 1);
        check("R5 cause bit2", rst_cause[2], 1);
        check("R8 hold while waking", io_hold, 1);
      end
      if (V_REQ[i] == 1) wait_ready("R3", lat_of(1));
      else if (V_REQ[i] == 2) wait_ready("R4", lat_of(2));
      else wait_ready("R5", lat_of(3));
    end

    // R7 clear all
    cause_clr = 3'b111;
    tick();
    cause_clr = 3'b000;
    check("R7 w1c clears", rst_cause, 3'b000);

    // R4 ignored sources in standby
    request(2);
    pulse(0);
    pulse(4);
    tick();
    check("R4 irq ignored in standby", mode_now, 2);
    pulse(3);
    wait_ready("R4", lat_of(2));

    // R5 ignored sources in shutdown
    request(3);
    pulse(0); pulse(1); pulse(2); pulse(3);
    check("R5 stays in shutdown", mode_now, 3);
    check("R5 bod off", bod_en, 0);
    check("R5 cause untouched", rst_cause, 3'b000);
    pulse(4);
    check("R5 shutdown wake cause", rst_cause, 3'b100);
    wait_ready("R5", lat_of(3));

    // R12 request outside active
    request(1);
    request(2);
    check("R12 request ignored", mode_now, 1);
    check("R12 err set", req_err, 1);
    pulse(0);
    wait_ready("R12", lat_of(1));
    check("R12 err sticky", req_err, 1);

    // R10 out-of-window trip ignored
    request(2);
    check("R10 window closed at entry", bod_en, 0);
    repeat (13) tick();
    check("R10 window closed phase 13", bod_en, 0);
    bod_trip = 1'b1;
    tick();
    bod_trip = 1'b0;
    check("R10 window open phase 14", bod_en, 1);
    pulse(1);
    check("R10 trip outside window ignored", mode_now, 4);
    wait_ready("R10", lat_of(2));
    check("R10 no lock", lock_out, 0);

    // R11 in-window trip locks
    request(2);
    repeat (14) tick();
    check("R11 window open", bod_en, 1);
    bod_trip = 1'b1;
    tick();
    bod_trip = 1'b0;
    check("R11 still standby", mode_now, 2);
    pulse(2);
    check("R11 locked", mode_now, 5);
    check("R11 lock_out", lock_out, 1);
    repeat (5) tick();
    check("R11 lock held", {lock_out, cpu_ready}, 2'b10);

    // R6 / R7 reset pin, set wins over clear
    rst_pin_n = 1'b0;
    cause_clr = 3'b010;
    tick();
    cause_clr = 3'b000;
    check("R7 set wins over clear", rst_cause, 3'b110);
    check("R6 reset held mode", mode_now, 6);
    check("R6 all off", {cpu_clk_en, flash_pwr_en, sram_pwr_en, radio_pwr_en,
                         periph_clk_en, aon_pwr_en, io_hold}, 7'd0);
    check("R6 sys_rst", sys_rst, 1);
    check("R11 lock cleared by pin", lock_out, 0);
    check("R12 err cleared by pin", req_err, 0);
    tick();
    check("R6 still held", mode_now, 6);
    rst_pin_n = 1'b1;
    tick();
    check("R6 waking after release", {mode_now, sys_rst}, {3'd4, 1'b1});
    wait_ready("R6", 1015);

    cause_clr = 3'b100;
    tick();
    cause_clr = 3'b000;
    check("R7 single bit clear", rst_cause, 3'b010);

    summary();
    $finish;
  end

endmodule